// File: doc/BRIEF.md
# Masked Byte-Lane VRAM Access Unit

This unit stands between a 32-bit processor-side port and a byte-wide video memory of 512 KiB. It takes one request at a time: a read of one, two or four bytes, or a write of two or four bytes, at any byte offset. It turns the request into a short run of single-byte memory cycles. The bytes come back assembled little-endian, with the lowest address in bits 7:0.

Every write is a read-modify-write. The unit first reads all the bytes the access touches. It then writes each byte back, merged with the new data under a 32-bit write mask. The mask is rotated so that its bytes follow the byte offset of the access.

An outside address decoder supplies a 2-bit window code. In the two layered windows, an access that runs past the end of a 256 KiB layer wraps to the start of the same layer. In the linear window, an access wraps at the top of the whole 512 KiB space.

Top module: `vram_rmw_unit`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and ram_en is 0, and the write mask holds all ones, so a write stores every bit of its data.
- R2: Size code 0 reads 1 byte, code 1 reads 2 bytes and codes 2 and 3 read 4 bytes. On done, rdata carries byte i of the access in bits 8i+7:8i (lowest address in bits 7:0) and zeros above the last byte.
- R3: Byte i of an access goes to start address plus i. This holds for an aligned access, and for a misaligned access that stays inside its layer or inside the 512 KiB space.
- R4: With window code 0 or 1 (layered), every byte of an access keeps bit 18 of the start address. Bits 17:0 count up modulo 2^18. For example, a start at 0x3FFFE continues at 0x00000, and a start at 0x7FFFF continues at 0x40000.
- R5: With window code 2 or 3 (linear), bytes count up modulo 2^19. For example, a start at 0x7FFFF continues at 0x00000, and a start at 0x3FFFF continues at 0x40000.
- R6: Each written byte equals (old AND NOT m) OR (new AND m), where old is the byte read in the same access. A zero mask therefore leaves memory unchanged.
- R7: The mask byte m for byte i is mask byte number (start[1:0] + i) mod 4, with mask byte 0 in bits 7:0.
- R8: The mask is loaded from mask_wdata when mask_we is 1. A request uses the mask held at the edge that accepts it. A load on that same edge, or during the access, takes effect only from the next request.
- R9: A request is accepted on an edge where req_valid and req_ready are both 1. Each byte read takes two cycles (issue, then capture one cycle later). A write then takes one cycle per byte. done is high for exactly one cycle, 2n edges (reads) or 3n edges (writes) after the accepting edge, where n is the byte count.
- R10: req_ready is 0 from acceptance through the done cycle, and 1 again in the following cycle. A req_valid while busy is ignored, and ram_en is 0 whenever req_ready is 1.
- R11: On done after a write, rdata holds the bytes as they were before the write, assembled as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | 1 | Load the write mask |
| mask_wdata | input | 32 | New write mask value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit is idle and accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Byte count code: 0 = 1, 1 = 2, 2 or 3 = 4 |
| req_window | input | 2 | 0 or 1 = layered wrap, 2 or 3 = linear wrap |
| req_addr | input | 19 | Start byte address |
| req_wdata | input | 32 | Write data, byte i in bits 8i+7:8i |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled bytes of the last access |
| ram_en | output | 1 | Memory cycle this clock |
| ram_we | output | 1 | Memory cycle is a write |
| ram_addr | output | 19 | Memory byte address |
| ram_wdata | output | 8 | Merged byte to store |
| ram_rdata | input | 8 | Byte read, valid the cycle after the read issue |

## Verification
A mask load can arrive on the same edge that accepts a request, or in the middle of an access. Either way the unit has to keep using the mask captured at acceptance. The bench provokes both cases with a misaligned write, so that the rotated old mask and the rotated new mask give different bytes. It judges the result on the merged byte of each memory write and then by reading the bytes back. A request raised while the unit is busy falls on the same cycles as an access in progress. The bench judges it ignored when the completion time is unchanged, no unexpected memory cycle appears, and the unit returns to idle.

// File: rtl/vram_rmw_pkg.sv
package vram_rmw_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_CAP, ST_WR, ST_DONE} seq_state_e;

  function automatic logic [2:0] lane_count(input logic [1:0] size_code);
    case (size_code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [7:0] merge_byte(input logic [7:0] old_b,
                                            input logic [7:0] new_b,
                                            input logic [7:0] m);
    return (old_b & ~m) | (new_b & m);
  endfunction

  function automatic logic [7:0] mask_lane(input logic [WORD_W-1:0] mask,
                                           input logic [LANE_W-1:0] offset,
                                           input logic [LANE_W-1:0] lane);
    logic [LANE_W-1:0] sel;
    sel = offset + lane;
    return mask[{sel, 3'b000} +: 8];
  endfunction
endpackage

// File: rtl/vram_mask_reg.sv
module vram_mask_reg #(
  parameter int MW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [MW-1:0] load_val,
  output logic [MW-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= '1;
    else if (load) mask_q <= load_val;
  end
endmodule

// File: rtl/vram_lane_gen.sv
module vram_lane_gen
  import vram_rmw_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic [AW-1:0]     base,
  input  logic              layered,
  input  logic [LANE_W-1:0] lane,
  input  logic [WORD_W-1:0] mask,
  output logic [AW-1:0]     addr,
  output logic [7:0]        mbyte
);
  localparam int LW = AW - 1;

  logic [AW-1:0] lin_addr;
  logic [LW-1:0] in_layer;

  always_comb begin
    lin_addr = base + AW'(lane);
    in_layer = base[LW-1:0] + LW'(lane);
    addr     = layered ? {base[AW-1], in_layer} : lin_addr;
    mbyte    = mask_lane(mask, base[LANE_W-1:0], lane);
  end
endmodule

// File: rtl/vram_rmw_seq.sv
module vram_rmw_seq
  import vram_rmw_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_window,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [WORD_W-1:0] mask_q,
  input  logic [7:0]        ram_rdata,
  output logic              req_ready,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [7:0]        ram_wdata,
  output logic [AW-1:0]     cur_base,
  output logic              cur_layered,
  output logic [7:0]        lane_mask,
  output logic [7:0]        lane_old
);
  seq_state_e        st_q;
  logic [LANE_W-1:0] k_q;
  logic [2:0]        cnt_q;
  logic              wr_q;
  logic              lay_q;
  logic [AW-1:0]     base_q;
  logic [WORD_W-1:0] wd_q, msk_q, old_q;
  logic              last_lane;

  assign last_lane = (3'(k_q) + 3'd1) == cnt_q;

  vram_lane_gen #(.AW(AW)) u_lane (
    .base(base_q), .layered(lay_q), .lane(k_q), .mask(msk_q),
    .addr(ram_addr), .mbyte(lane_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      lay_q  <= 1'b0;
      base_q <= '0;
      wd_q   <= '0;
      msk_q  <= '0;
      old_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          st_q   <= ST_RD;
          k_q    <= '0;
          cnt_q  <= lane_count(req_size);
          wr_q   <= req_write;
          lay_q  <= ~req_window[1];
          base_q <= req_addr;
          wd_q   <= req_wdata;
          msk_q  <= mask_q;
          old_q  <= '0;
        end
        ST_RD: st_q <= ST_CAP;
        ST_CAP: begin
          old_q[{k_q, 3'b000} +: 8] <= ram_rdata;
          if (last_lane) begin
            k_q  <= '0;
            st_q <= wr_q ? ST_WR : ST_DONE;
          end else begin
            k_q  <= k_q + 1'b1;
            st_q <= ST_RD;
          end
        end
        ST_WR: begin
          if (last_lane) st_q <= ST_DONE;
          else           k_q  <= k_q + 1'b1;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready   = (st_q == ST_IDLE);
    done        = (st_q == ST_DONE);
    ram_en      = (st_q == ST_RD) || (st_q == ST_WR);
    ram_we      = (st_q == ST_WR);
    lane_old    = old_q[{k_q, 3'b000} +: 8];
    ram_wdata   = merge_byte(lane_old, wd_q[{k_q, 3'b000} +: 8], lane_mask);
    rdata       = old_q;
    cur_base    = base_q;
    cur_layered = lay_q;
  end
endmodule

// File: rtl/vram_rmw_unit.sv
module vram_rmw_unit
  import vram_rmw_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we,
  input  logic [31:0]   mask_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [1:0]    req_window,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata
);
  logic [WORD_W-1:0] mask_q;
  logic [AW-1:0]     cur_base;
  logic              cur_layered;
  logic [7:0]        lane_mask;
  logic [7:0]        lane_old;

  vram_mask_reg #(.MW(WORD_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(mask_we), .load_val(mask_wdata), .mask_q(mask_q)
  );

  vram_rmw_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_window(req_window), .req_addr(req_addr),
    .req_wdata(req_wdata), .mask_q(mask_q), .ram_rdata(ram_rdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .cur_base(cur_base), .cur_layered(cur_layered),
    .lane_mask(lane_mask), .lane_old(lane_old)
  );
endmodule

// File: rtl/vram_rmw_chk.sv
module vram_rmw_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          ram_en,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [7:0]    ram_wdata,
  input logic [AW-1:0] cur_base,
  input logic          cur_layered,
  input logic [7:0]    lane_mask,
  input logic [7:0]    lane_old
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ram_en);  // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);  // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));  // R9
  AST_LAYER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && cur_layered) |-> (ram_addr[AW-1] == cur_base[AW-1]));  // R4
  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && lane_mask == 8'h00) |-> (ram_wdata == lane_old));  // R6
endmodule

bind vram_rmw_unit vram_rmw_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
  .ram_wdata(ram_wdata), .cur_base(cur_base), .cur_layered(cur_layered),
  .lane_mask(lane_mask), .lane_old(lane_old)
);

// File: tb/tb_vram_rmw_unit.sv
module tb_vram_rmw_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mask_we = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_window = '0;
  logic [18:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic        ram_en, ram_we;
  logic [18:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit bench_busy = 1'b0;
  logic [31:0] ref_mask = 32'hFFFF_FFFF;
  logic [7:0] mem [int];
  logic [7:0] ref_mem [int];
  int exp_a [$];
  logic [7:0] exp_d [$];

  always #2 clk = ~clk;

  vram_rmw_unit dut (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_window(req_window), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] fill(input int a);
    return 8'((a ^ (a >> 8) ^ (a >> 16)) + 8'h3c);
  endfunction

  function automatic logic [7:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : fill(a);
  endfunction

  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : fill(a);
  endfunction

  function automatic void chk(input bit ok, input string req, input logic [31:0] act,
                              input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  // Byte-wide memory with one cycle of read latency
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[int'(ram_addr)] = ram_wdata;
      else        ram_rdata <= mem_rd(int'(ram_addr));
    end
  end

  // Per-clock comparison of memory writes against the reference queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_en && !bench_busy)
        chk(1'b0, "R10 memory cycle while idle", 32'(ram_addr), 32'h0);
      if (ram_en && ram_we) begin
        if (exp_a.size() == 0) chk(1'b0, "R6 unexpected write", 32'(ram_addr), 32'h0);
        else begin
          int a;
          logic [7:0] d;
          a = exp_a.pop_front();
          d = exp_d.pop_front();
          chk(32'(ram_addr) == a && ram_wdata == d, "R6/R7 write lane",
              {5'b0, ram_addr, ram_wdata}, {a[23:0], d});
        end
      end
    end
  end

  task automatic load_mask(input logic [31:0] m);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = m;
    @(negedge clk);
    mask_we = 1'b0;
    ref_mask = m;
  endtask

  // mask_evt: 0 none, 1 load on accept edge, 2 load mid-access
  task automatic access(input bit wr, input logic [1:0] sz, input logic [1:0] win,
                        input int addr, input logic [31:0] wd, input string tag,
                        input int mask_evt, input logic [31:0] newm, input bit poke);
    int n, edges;
    logic [31:0] exp_rd;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    exp_rd = '0;
    for (int i = 0; i < n; i++) begin
      int a;
      logic [7:0] old, m, nb;
      a = (win < 2) ? (((addr + i) & 'h3FFFF) | (addr & 'h40000)) : ((addr + i) & 'h7FFFF);
      old = ref_rd(a);
      exp_rd = exp_rd | (32'(old) << (8 * i));
      if (wr) begin
        m  = 8'(ref_mask >> (8 * ((addr + i) % 4)));
        nb = (old & ~m) | (8'(wd >> (8 * i)) & m);
        exp_a.push_back(a);
        exp_d.push_back(nb);
        ref_mem[a] = nb;
      end
    end
    if (mask_evt != 0) ref_mask = newm;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready before request", 32'(req_ready), 32'h1);
    bench_busy = 1'b1;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_window = win;
    req_addr = 19'(addr); req_wdata = wd;
    if (mask_evt == 1) begin mask_we = 1'b1; mask_wdata = newm; end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    mask_we = 1'b0;
    edges = 0;
    while (1) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (done) break;
      if (edges > 40) break;
      if (mask_evt == 2 && edges == 1) begin mask_we = 1'b1; mask_wdata = newm; end
      if (mask_evt == 2 && edges == 2) mask_we = 1'b0;
      if (poke && edges == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'(addr + 64); req_size = 2'd2;
      end
      if (poke && edges == 3) req_valid = 1'b0;
    end
    mask_we = 1'b0;
    chk(edges == (wr ? 3 * n : 2 * n), {"R9 done timing ", tag}, 32'(edges),
        32'(wr ? 3 * n : 2 * n));
    chk(rdata == exp_rd, {wr ? "R11 old bytes " : "R2 read data ", tag}, rdata, exp_rd);
    chk(exp_a.size() == 0, {"R6 all lanes written ", tag}, 32'(exp_a.size()), 32'h0);
    @(negedge clk);
    chk(req_ready && !ram_en && !done, {"R10 idle after done ", tag},
        {29'b0, req_ready, ram_en, done}, 32'h4);
    bench_busy = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1 && done === 1'b0 && ram_en === 1'b0, "R1 reset outputs",
        {29'b0, req_ready, done, ram_en}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    // R2/R3 aligned and misaligned reads, sizes 4, 1, 2
    access(0, 2'd2, 2'd0, 'h100, 0, "rd32 aligned", 0, 0, 0);
    access(0, 2'd0, 2'd2, 'h103, 0, "rd8", 0, 0, 0);
    access(0, 2'd1, 2'd0, 'h101, 0, "rd16 off1", 0, 0, 0);
    access(0, 2'd3, 2'd1, 'h3FFFB, 0, "R3 rd32 near layer end", 0, 0, 0);
    // R1 reset mask is all ones: full write, then read back
    access(1, 2'd2, 2'd2, 'h200, 32'hDEAD_BEEF, "R1 unmasked wr32", 0, 0, 0);
    access(0, 2'd2, 2'd2, 'h200, 0, "R1 readback", 0, 0, 0);
    // R7 rotated mask
    load_mask(32'h0F0F_F00F);
    access(1, 2'd2, 2'd0, 'h301, 32'h1234_5678, "R7 wr32 off1", 0, 0, 0);
    access(0, 2'd2, 2'd0, 'h301, 0, "R7 readback", 0, 0, 0);
    access(1, 2'd1, 2'd2, 'h403, 32'h0000_A5C3, "R7 wr16 off3", 0, 0, 0);
    access(1, 2'd2, 2'd0, 'h502, 32'hCAFE_F00D, "R7 wr32 off2", 0, 0, 0);
    access(0, 2'd2, 2'd2, 'h500, 0, "R7 readback", 0, 0, 0);
    // R4 layered wrap
    access(1, 2'd2, 2'd0, 'h3FFFE, 32'h9988_7766, "R4 wr32 layer0 wrap", 0, 0, 0);
    access(0, 2'd1, 2'd2, 'h00000, 0, "R4 low bytes", 0, 0, 0);
    access(0, 2'd2, 2'd1, 'h7FFFD, 0, "R4 rd32 layer1 wrap", 0, 0, 0);
    access(0, 2'd1, 2'd0, 'h7FFFF, 0, "R4 rd16 layer1 wrap", 0, 0, 0);
    // R5 linear wrap
    access(1, 2'd1, 2'd2, 'h7FFFF, 32'h0000_4321, "R5 wr16 top wrap", 0, 0, 0);
    access(0, 2'd2, 2'd3, 'h7FFFE, 0, "R5 rd32 top wrap", 0, 0, 0);
    access(0, 2'd2, 2'd2, 'h3FFFF, 0, "R5 rd32 crosses layer", 0, 0, 0);
    // R8 mask load on the accepting edge and during the access
    load_mask(32'hFF00_00FF);
    access(1, 2'd2, 2'd2, 'h601, 32'h5555_AAAA, "R8 load on accept", 1, 32'h00FF_FF00, 0);
    access(0, 2'd2, 2'd2, 'h601, 0, "R8 readback", 0, 0, 0);
    access(1, 2'd2, 2'd2, 'h703, 32'h1357_9BDF, "R8 load mid-access", 2, 32'hF0F0_0F0F, 0);
    access(0, 2'd2, 2'd2, 'h703, 0, "R8 readback mid", 0, 0, 0);
    // R10 request while busy is ignored
    access(0, 2'd2, 2'd0, 'h800, 0, "R10 busy poke", 0, 0, 1);
    access(0, 2'd2, 2'd0, 'h840, 0, "R10 poke target untouched", 0, 0, 0);
    // R6 zero mask keeps memory
    load_mask(32'h0000_0000);
    access(1, 2'd2, 2'd0, 'h900, 32'hFFFF_FFFF, "R6 zero mask", 0, 0, 0);
    access(0, 2'd2, 2'd0, 'h900, 0, "R6 readback", 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule